// File: doc/BRIEF.md
# Two-Word Burst Quad-Data-Rate SRAM Model

A synthesizable model of a quad-data-rate static memory that moves two words per access. It serves as a test partner for a memory controller. Reads and writes have their own data ports but share one address bus. A single clock `clk_i` stands in for both input clock phases: its rising edge is the primary phase and its falling edge is the complementary phase. Read data is also launched from these two edges, which is the single-clock mode.

Each operation starts at a rising edge through an active-low select, one for reads and one for writes. Both operations may start in the same cycle. The read address is taken at the rising edge. The write address is taken at the falling edge of the same cycle. Write data and byte enables are taken on both edges. A write is held in registers and only reaches the array at the next rising edge. A read that hits a held write receives the new data, after byte masking. Storage depth is a parameter.

Top module: `qdr_burst_sram`

## Requirements
- R1: While `rst_ni` is low, `q_valid_o` is 0 and `q_o` is 0.
- R2: With `rps_ni` low at rising edge n, `q_valid_o` is 1 for all of cycle n+1. `q_o` carries word A (the address taken at edge n) from rising edge n+1 until the falling edge. From that falling edge until rising edge n+2 it carries the partner word.
- R3: With `wps_ni` low at rising edge n, two words are written. The `d_i`/`bw_ni` values at rising edge n go to address B. The values at the falling edge of cycle n go to the partner of B. B is `addr_i` sampled at that falling edge.
- R4: The partner address is the address with bit 0 inverted. An odd first address therefore returns address-1 as its second word.
- R5: `bw_ni` is active low. Bit 0 enables `d_i[8:0]` and bit 1 enables `d_i[17:9]`. A disabled byte keeps its previous array value.
- R6: A write is committed to the array at the rising edge after it was captured. A read started in the same cycle as a write to the same pair returns the new, byte-masked data. A read started in the next cycle returns the committed data.
- R7: Reads may start in consecutive cycles. `q_valid_o` then stays 1 and each cycle carries its own read's two words.
- R8: In a cycle with no read data, `q_valid_o` is 0 and `q_o` holds the last word driven.
- R9: A read and a write to different pairs in the same cycle both complete correctly.
- R10: With `wps_ni` high at a rising edge, `d_i`, `bw_ni` and the falling-edge address are ignored and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock. The rising edge is the primary phase and the falling edge the complementary phase. |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rps_ni | input | 1 | Read select, active low, sampled at the rising edge |
| wps_ni | input | 1 | Write select, active low, sampled at the rising edge |
| addr_i | input | AW (10) | Shared address. Read address at the rising edge, write address at the falling edge. |
| d_i | input | DW (18) | Write data, sampled on both edges |
| bw_ni | input | NBYTE (2) | Byte-write enables, active low, sampled on both edges |
| q_o | output | DW (18) | Read data, two words per cycle |
| q_valid_o | output | 1 | High during a cycle that carries read data |

## Verification
A read and a posted write can fall in the same cycle and target the same pair. The read then has to see data that is not yet in the array. The bench provokes this by starting both operations in one cycle. The write carries a different byte enable per word over a pair whose values are already known. The two returned words are compared with hand-computed masked values, and a lone read of the pair afterwards confirms that the commit matches the forwarded data.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int unsigned DEF_DEPTH = 1024;
  localparam int unsigned DEF_DW    = 18;
  localparam int unsigned DEF_NBYTE = 2;

  typedef enum logic {
    HALF_FIRST  = 1'b0,
    HALF_SECOND = 1'b1
  } half_e;
endpackage

// File: rtl/qdr_in_capture.sv
module qdr_in_capture #(
  parameter int unsigned AW    = 10,
  parameter int unsigned DW    = 18,
  parameter int unsigned NBYTE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rps_ni,
  input  logic             wps_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    d_i,
  input  logic [NBYTE-1:0] bw_ni,
  output logic             rd_req_o,
  output logic [AW-1:0]    rd_addr_o,
  output logic             wr_req_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_d0_o,
  output logic [NBYTE-1:0] wr_be0_o,
  output logic [DW-1:0]    wr_d1_o,
  output logic [NBYTE-1:0] wr_be1_o
);
  // rising-edge half: selects, read address, first write word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
      wr_req_o  <= 1'b0;
      wr_d0_o   <= '0;
      wr_be0_o  <= '0;
    end else begin
      rd_req_o <= ~rps_ni;
      wr_req_o <= ~wps_ni;
      if (!rps_ni) rd_addr_o <= addr_i;
      if (!wps_ni) begin
        wr_d0_o  <= d_i;
        wr_be0_o <= ~bw_ni;
      end
    end
  end

  // falling-edge half: write address and second word; only used when wr_req_o
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_addr_o <= '0;
      wr_d1_o   <= '0;
      wr_be1_o  <= '0;
    end else if (wr_req_o) begin
      wr_addr_o <= addr_i;
      wr_d1_o   <= d_i;
      wr_be1_o  <= ~bw_ni;
    end
  end
endmodule

// File: rtl/qdr_store.sv
module qdr_store #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = 10,
  parameter int unsigned DW    = 18,
  parameter int unsigned NBYTE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_req_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic             wr_req_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_d0_i,
  input  logic [NBYTE-1:0] wr_be0_i,
  input  logic [DW-1:0]    wr_d1_i,
  input  logic [NBYTE-1:0] wr_be1_i,
  output logic             rd_vld_o,
  output logic [DW-1:0]    rd_q0_o,
  output logic [DW-1:0]    rd_q1_o
);
  localparam int unsigned BYTE_W = DW / NBYTE;

  logic [DW-1:0] mem_q [DEPTH];

  logic [AW-1:0] wa0, wa1, ra0, ra1;
  logic [DW-1:0] new_w0, new_w1, rq0, rq1;

  assign wa0 = wr_addr_i;
  assign wa1 = {wr_addr_i[AW-1:1], ~wr_addr_i[0]};
  assign ra0 = rd_addr_i;
  assign ra1 = {rd_addr_i[AW-1:1], ~rd_addr_i[0]};

  // byte-masked merge of the held write onto the current array contents
  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    assign new_w0[b*BYTE_W +: BYTE_W] = wr_be0_i[b] ? wr_d0_i[b*BYTE_W +: BYTE_W]
                                                    : mem_q[wa0][b*BYTE_W +: BYTE_W];
    assign new_w1[b*BYTE_W +: BYTE_W] = wr_be1_i[b] ? wr_d1_i[b*BYTE_W +: BYTE_W]
                                                    : mem_q[wa1][b*BYTE_W +: BYTE_W];
  end

  // forwarding: the held write is committed at this same edge
  always_comb begin
    rq0 = mem_q[ra0];
    rq1 = mem_q[ra1];
    if (wr_req_i) begin
      if (ra0 == wa0) rq0 = new_w0;
      else if (ra0 == wa1) rq0 = new_w1;
      if (ra1 == wa0) rq1 = new_w0;
      else if (ra1 == wa1) rq1 = new_w1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_req_i) begin
      mem_q[wa0] <= new_w0;
      mem_q[wa1] <= new_w1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_o <= 1'b0;
      rd_q0_o  <= '0;
      rd_q1_o  <= '0;
    end else begin
      rd_vld_o <= rd_req_i;
      if (rd_req_i) begin
        rd_q0_o <= rq0;
        rd_q1_o <= rq1;
      end
    end
  end
endmodule

// File: rtl/qdr_out_ddr.sv
module qdr_out_ddr
  import qdr_pkg::*;
#(
  parameter int unsigned DW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [DW-1:0] q0_i,
  input  logic [DW-1:0] q1_i,
  output logic [DW-1:0] q_o,
  output logic          q_valid_o
);
  logic    p_tog_q, n_tog_q;
  logic [DW-1:0] last_q;
  half_e   half;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_tog_q <= 1'b0;
      last_q  <= '0;
    end else begin
      p_tog_q <= ~p_tog_q;
      if (vld_i) last_q <= q1_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) n_tog_q <= 1'b0;
    else         n_tog_q <= p_tog_q;
  end

  // toggles differ between rising and falling edge, match afterwards
  assign half      = (p_tog_q != n_tog_q) ? HALF_FIRST : HALF_SECOND;
  assign q_o       = !vld_i ? last_q : (half == HALF_FIRST) ? q0_i : q1_i;
  assign q_valid_o = vld_i;
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
  import qdr_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned DW    = DEF_DW,
  parameter int unsigned NBYTE = DEF_NBYTE,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rps_ni,
  input  logic             wps_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    d_i,
  input  logic [NBYTE-1:0] bw_ni,
  output logic [DW-1:0]    q_o,
  output logic             q_valid_o
);
  logic             rd_req, wr_req, rd_vld;
  logic [AW-1:0]    rd_addr, wr_addr;
  logic [DW-1:0]    wr_d0, wr_d1, rd_q0, rd_q1;
  logic [NBYTE-1:0] wr_be0, wr_be1;

  qdr_in_capture #(.AW(AW), .DW(DW), .NBYTE(NBYTE)) u_cap (
    .clk_i, .rst_ni, .rps_ni, .wps_ni, .addr_i, .d_i, .bw_ni,
    .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .wr_req_o(wr_req), .wr_addr_o(wr_addr),
    .wr_d0_o(wr_d0), .wr_be0_o(wr_be0),
    .wr_d1_o(wr_d1), .wr_be1_o(wr_be1)
  );

  qdr_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .NBYTE(NBYTE)) u_store (
    .clk_i, .rst_ni,
    .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .wr_req_i(wr_req), .wr_addr_i(wr_addr),
    .wr_d0_i(wr_d0), .wr_be0_i(wr_be0),
    .wr_d1_i(wr_d1), .wr_be1_i(wr_be1),
    .rd_vld_o(rd_vld), .rd_q0_o(rd_q0), .rd_q1_o(rd_q1)
  );

  qdr_out_ddr #(.DW(DW)) u_out (
    .clk_i, .rst_ni,
    .vld_i(rd_vld), .q0_i(rd_q0), .q1_i(rd_q1),
    .q_o, .q_valid_o
  );
endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk #(
  parameter int unsigned DW = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rps_ni,
  input logic [DW-1:0] q_o,
  input logic          q_valid_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (!q_valid_o && q_o == '0);
    end
  end

  p_read_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rps_ni |=> ##1 q_valid_o);

  p_valid_source_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o |-> !$past(rps_ni, 2));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rps_ni |=> ##1 (!q_valid_o && $stable(q_o)));
endmodule

bind qdr_burst_sram qdr_burst_sram_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rps_ni(rps_ni), .q_o(q_o), .q_valid_o(q_valid_o)
);

// File: tb/qdr_burst_sram_tb.sv
module qdr_burst_sram_tb_top;
  localparam int unsigned AW = 10;
  localparam int unsigned DW = 18;

  typedef struct packed {
    logic          rd;
    logic [AW-1:0] ra;
    logic          wr;
    logic [AW-1:0] wa;
    logic [DW-1:0] d0;
    logic [1:0]    b0;
    logic [DW-1:0] d1;
    logic [1:0]    b1;
    logic [DW-1:0] e0;
    logic [DW-1:0] e1;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    // R3: write pair 4/5
    '{1'b0, 10'd0, 1'b1, 10'd4, 18'h12345, 2'b00, 18'h2ABCD, 2'b00, 18'h0, 18'h0},
    // R2: read 4
    '{1'b1, 10'd4, 1'b0, 10'd0, 18'h0, 2'b11, 18'h0, 2'b11, 18'h12345, 18'h2ABCD},
    // R4: odd start wraps to 4
    '{1'b1, 10'd5, 1'b0, 10'd0, 18'h0, 2'b11, 18'h0, 2'b11, 18'h2ABCD, 18'h12345},
    // R9: read 4 with write 8/9
    '{1'b1, 10'd4, 1'b1, 10'd8, 18'h3FFFF, 2'b00, 18'h00000, 2'b00, 18'h12345, 18'h2ABCD},
    // R5 R6: read 8 with masked write 8/9 in same cycle
    '{1'b1, 10'd8, 1'b1, 10'd8, 18'h15555, 2'b10, 18'h2AAAA, 2'b01, 18'h3FF55, 18'h2AA00},
    // R6: committed values
    '{1'b1, 10'd9, 1'b0, 10'd0, 18'h0, 2'b11, 18'h0, 2'b11, 18'h2AA00, 18'h3FF55},
    // R10: write select high, garbage data toward 4
    '{1'b0, 10'd0, 1'b0, 10'd4, 18'h00000, 2'b00, 18'h00000, 2'b00, 18'h0, 18'h0},
    // R10: pair 4 unchanged
    '{1'b1, 10'd4, 1'b0, 10'd0, 18'h0, 2'b11, 18'h0, 2'b11, 18'h12345, 18'h2ABCD}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rps_n = 1'b1, wps_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d = '0;
  logic [1:0]    bw_n = 2'b11;
  logic [DW-1:0] q;
  logic          q_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  qdr_burst_sram dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rps_ni(rps_n), .wps_ni(wps_n),
    .addr_i(addr), .d_i(d), .bw_ni(bw_n), .q_o(q), .q_valid_o(q_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drives one cycle: first half before rising edge, second half before falling edge
  task automatic do_op(input logic rd, input logic [AW-1:0] ra, input logic wr,
                       input logic [AW-1:0] wa, input logic [DW-1:0] d0,
                       input logic [1:0] b0, input logic [DW-1:0] d1, input logic [1:0] b1);
    rps_n = ~rd; wps_n = ~wr; addr = ra; d = d0; bw_n = b0;
    @(posedge clk); #2;
    addr = wa; d = d1; bw_n = b1;
    @(negedge clk); #2;
    rps_n = 1'b1; wps_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(q_valid == 1'b0, "R1 valid in reset", {17'd0, q_valid}, 18'd0);
    chk(q == '0, "R1 data in reset", q, 18'd0);
    @(negedge clk); rst_n = 1'b1; #2;

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i].rd, VEC[i].ra, VEC[i].wr, VEC[i].wa, VEC[i].d0, VEC[i].b0,
            VEC[i].d1, VEC[i].b1);
      #4;
      if (VEC[i].rd) begin
        chk(q_valid == 1'b1, $sformatf("R2 vec%0d valid", i), {17'd0, q_valid}, 18'd1);
        chk(q == VEC[i].e0, $sformatf("R2 vec%0d first word", i), q, VEC[i].e0);
      end
      #4;
      if (VEC[i].rd)
        chk(q == VEC[i].e1, $sformatf("R4 vec%0d second word", i), q, VEC[i].e1);
    end

    // R7 back-to-back reads, then R8 idle hold
    fork
      begin
        do_op(1'b1, 10'd4, 1'b0, 10'd0, 18'h0, 2'b11, 18'h0, 2'b11);
        do_op(1'b1, 10'd8, 1'b0, 10'd0, 18'h0, 2'b11, 18'h0, 2'b11);
        do_op(1'b1, 10'd9, 1'b0, 10'd0, 18'h0, 2'b11, 18'h0, 2'b11);
      end
      begin
        @(posedge clk); #10;
        chk(q == 18'h12345 && q_valid, "R7 read0 word0", q, 18'h12345); #4;
        chk(q == 18'h2ABCD && q_valid, "R7 read0 word1", q, 18'h2ABCD); #4;
        chk(q == 18'h3FF55 && q_valid, "R7 read1 word0", q, 18'h3FF55); #4;
        chk(q == 18'h2AA00 && q_valid, "R7 read1 word1", q, 18'h2AA00); #4;
        chk(q == 18'h2AA00 && q_valid, "R7 read2 word0", q, 18'h2AA00); #4;
        chk(q == 18'h3FF55 && q_valid, "R7 read2 word1", q, 18'h3FF55); #4;
        chk(q_valid == 1'b0, "R8 idle valid", {17'd0, q_valid}, 18'd0);
        chk(q == 18'h3FF55, "R8 idle hold first half", q, 18'h3FF55); #4;
        chk(q == 18'h3FF55, "R8 idle hold second half", q, 18'h3FF55); #4;
      end
    join

    // R6 write then read of the pair in the very next cycle
    do_op(1'b0, 10'd0, 1'b1, 10'd12, 18'h0F0F0, 2'b00, 18'h30303, 2'b00);
    do_op(1'b1, 10'd13, 1'b0, 10'd0, 18'h0, 2'b11, 18'h0, 2'b11);
    #4;
    chk(q == 18'h30303, "R6 next-cycle read word0", q, 18'h30303);
    #4;
    chk(q == 18'h0F0F0, "R6 next-cycle read word1", q, 18'h0F0F0);

    // R1 asynchronous reset mid-run
    #3;
    rst_n = 1'b0;
    #1;
    chk(q_valid == 1'b0, "R1 valid after async reset", {17'd0, q_valid}, 18'd0);
    chk(q == '0, "R1 data after async reset", q, 18'd0);

    done = 1'b1;
    finish_run();
  end
endmodule